// File: doc/BRIEF.md
# SMBus Configuration-Read Bridge Slave

This block is the transaction layer of an SMBus slave that turns SMBus traffic into internal 32-bit configuration reads. A bit engine handles SCL/SDA and presents a byte-level link. It signals start, repeated start and stop conditions and each received byte. It collects an ACK/NAK decision for every received byte, takes the byte to transmit, and reports whether the master acknowledged it. It also obeys a hold request that stretches the clock.

A host stages a target address with one or more SMBus writes. The address is a bus number, a device/function byte and a 16-bit register number, and it can arrive through any mix of byte, word and block writes. The write that carries the End flag launches an internal read. The bridge holds the clock until the response or an internal timeout. It then ACKs the final byte, or NAKs it on an abort or timeout. The host then sends a command, a repeated start and a read address. It gets back a byte count of five, a status byte and the four data bytes, most significant first, followed by a CRC-8 packet error code when the command asks for one.

Top module: `smb_cfgrd_bridge`

## Requirements
- R1: The slave address is the 7-bit value {1, 1, strap[3], 0, strap[2], strap[1], strap[0]}, followed by the direction bit in bit 0 (0 = write, 1 = read). An address byte that does not match is NAKed, and every later byte is NAKed until the next start.
- R2: The command byte is split into fields. Bit 7 is Begin and clears the staging pointer. Bit 6 is End. Bit 4 enables PEC. Bits 3:2 are the internal command and must be 00 (read DWORD). Bits 1:0 give the size: 00 is one data byte, 01 is two, and 10 is a block that starts with a byte count. A command with bits 3:2 other than 00, or with size 11, is NAKed.
- R3: Staged bytes fill a pointer-ordered store. Byte 0 is the bus number, byte 1 the device/function, byte 2 register bits 7:0 and byte 3 register bits 15:8. Any mix of write sizes fills it, and bytes after the fourth are ignored.
- R4: The final byte of an End write is the last data byte, or the PEC byte when PEC is on. That byte gets no immediate decision. Instead cfg_req and lnk_hold rise together, and cfg_bus, cfg_devfn and cfg_reg show the staged values and stay stable while the request is open.
- R5: A response without abort flags ACKs the held byte in the cycle after cfg_rsp_valid, and lnk_hold drops in the same cycle.
- R6: A response with a master or target abort NAKs the held byte instead of ACKing it.
- R7: If no response arrives within TMO_CYCLES cycles, the held byte is NAKed, the request is withdrawn and status bit 7 is recorded.
- R8: A read is accepted after a command byte, a repeated start and the read address. It returns byte count 5, then the status byte, then data bits 31:24, 23:16, 15:8 and 7:0, then the PEC byte if that command has bit 4 set.
- R9: The status byte sets bit 0 for success, bit 4 for a target abort, bit 5 for a master abort and bit 7 for a timeout. All other bits are 0.
- R10: The PEC is CRC-8 with polynomial x^8+x^2+x+1 and initial value 0, computed over every byte from the start, address bytes included. A write whose PEC byte does not match is NAKed and launches no read.
- R11: The transmitted PEC covers the write address, the command, the read address, the count, the status and the four data bytes.
- R12: When the master NAKs a transmitted byte, the slave returns to idle. lnk_tx_byte then reads 0xFF, the released bus value.
- R13: A read address is NAKed when no completed result is held, or when no command byte came before it in the same transaction.
- R14: Every received byte other than the held final byte gets its decision on lnk_ack_valid exactly one cycle after lnk_rx_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_addr | input | 4 | Straps for the don't-care slave address bits |
| lnk_start | input | 1 | Start condition seen (pulse) |
| lnk_rstart | input | 1 | Repeated start seen (pulse) |
| lnk_stop | input | 1 | Stop condition seen (pulse) |
| lnk_rx_valid | input | 1 | A received byte is presented (pulse) |
| lnk_rx_byte | input | 8 | Received byte; for an address byte, bit 0 is the direction |
| lnk_ack_valid | output | 1 | Decision for the last received byte (pulse) |
| lnk_ack_nak | output | 1 | 1 = NAK, 0 = ACK, qualified by lnk_ack_valid |
| lnk_hold | output | 1 | Clock-stretch request while the internal read is open |
| lnk_tx_byte | output | 8 | Byte to transmit in a read; 0xFF when not transmitting |
| lnk_tx_ack | input | 1 | Master ACKed the transmitted byte (pulse) |
| lnk_tx_nak | input | 1 | Master NAKed the transmitted byte (pulse) |
| cfg_req | output | 1 | Internal configuration read request (level) |
| cfg_bus | output | 8 | Bus number of the request |
| cfg_devfn | output | 8 | Device/function of the request |
| cfg_reg | output | 16 | Register number of the request |
| cfg_rsp_valid | input | 1 | Response valid (pulse) |
| cfg_rsp_data | input | 32 | Read data |
| cfg_rsp_mabort | input | 1 | Internal master abort |
| cfg_rsp_tabort | input | 1 | Internal target abort |

## Verification
The bench builds the bridge with TMO_CYCLES set to 40 instead of the default 200000, which is about 2 ms at 100 MHz. With that value the timeout path, its NAK, its status bit and the withdrawn request all happen within a few dozen cycles, and the bench can bound the cycle of the timeout decision. The straps are tied to 1010, so one address bit that depends on a strap separates the matching address from a near miss.

// File: rtl/smb_cfgrd_pkg.sv
package smb_cfgrd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_DATA, ST_PEC, ST_WAIT, ST_TX, ST_SKIP
    } state_e;

    // Command byte fields
    localparam int CMD_BEGIN = 7;
    localparam int CMD_END   = 6;
    localparam int CMD_PEC   = 4;
    localparam logic [1:0] ICMD_RD_DWORD = 2'b00;
    localparam logic [1:0] SZ_BYTE  = 2'b00;
    localparam logic [1:0] SZ_WORD  = 2'b01;
    localparam logic [1:0] SZ_BLOCK = 2'b10;

    // Staging store and read-back framing
    localparam int STAGE_BYTES = 4;
    localparam int RD_COUNT    = 5;
    localparam int TXI_PAYLOAD = RD_COUNT;       // last payload index
    localparam int TXI_PEC     = RD_COUNT + 1;   // PEC index

    // Status byte bit positions
    localparam int SB_TMO  = 7;
    localparam int SB_MABT = 5;
    localparam int SB_TABT = 4;
    localparam int SB_OK   = 0;

    typedef struct packed {
        state_e      st;
        logic [2:0]  ptr;
        logic [7:0]  rem;
        logic        fin_end;
        logic        fin_pec;
        logic        got_cmd;
        logic [7:0]  bus;
        logic [7:0]  devfn;
        logic [15:0] regn;
        logic [7:0]  crc;
        logic        rdy;
        logic [7:0]  status;
        logic [31:0] rdata;
        logic [2:0]  txi;
        logic        ack_v;
        logic        ack_nak;
    } regs_t;

endpackage

// File: rtl/smb_crc8_step.sv
module smb_crc8_step #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);
    always_comb begin
        logic [7:0] acc;
        acc = crc_in ^ data_in;
        for (int i = 0; i < 8; i++) begin
            acc = acc[7] ? ((acc << 1) ^ POLY) : (acc << 1);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/smb_cfg_timeout.sv
module smb_cfg_timeout #(
    parameter int unsigned LIMIT = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expire = run && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = run ? (cnt_q + 1'b1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire); // R7
endmodule

// File: rtl/smb_cfgrd_bridge.sv
module smb_cfgrd_bridge
    import smb_cfgrd_pkg::*;
#(
    parameter int unsigned TMO_CYCLES = 200000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  strap_addr,
    input  logic        lnk_start,
    input  logic        lnk_rstart,
    input  logic        lnk_stop,
    input  logic        lnk_rx_valid,
    input  logic [7:0]  lnk_rx_byte,
    output logic        lnk_ack_valid,
    output logic        lnk_ack_nak,
    output logic        lnk_hold,
    output logic [7:0]  lnk_tx_byte,
    input  logic        lnk_tx_ack,
    input  logic        lnk_tx_nak,
    output logic        cfg_req,
    output logic [7:0]  cfg_bus,
    output logic [7:0]  cfg_devfn,
    output logic [15:0] cfg_reg,
    input  logic        cfg_rsp_valid,
    input  logic [31:0] cfg_rsp_data,
    input  logic        cfg_rsp_mabort,
    input  logic        cfg_rsp_tabort
);
    regs_t r_d, r_q;
    logic [6:0] own_addr;
    logic [7:0] crc_din, crc_nx;
    logic [2:0] tx_last;
    logic       tmo;

    assign own_addr = {2'b11, strap_addr[3], 1'b0, strap_addr[2:0]};
    assign tx_last  = r_q.fin_pec ? 3'(TXI_PEC) : 3'(TXI_PAYLOAD);

    smb_crc8_step #(.POLY(8'h07)) u_crc (
        .crc_in (r_q.crc),
        .data_in(crc_din),
        .crc_out(crc_nx)
    );

    smb_cfg_timeout #(.LIMIT(TMO_CYCLES)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.st == ST_WAIT),
        .expire(tmo)
    );

    // Transmit byte selection
    always_comb begin
        lnk_tx_byte = 8'hFF;
        if (r_q.st == ST_TX) begin
            case (r_q.txi)
                3'd0:    lnk_tx_byte = 8'(RD_COUNT);
                3'd1:    lnk_tx_byte = r_q.status;
                3'd2:    lnk_tx_byte = r_q.rdata[31:24];
                3'd3:    lnk_tx_byte = r_q.rdata[23:16];
                3'd4:    lnk_tx_byte = r_q.rdata[15:8];
                3'd5:    lnk_tx_byte = r_q.rdata[7:0];
                3'd6:    lnk_tx_byte = r_q.crc;
                default: lnk_tx_byte = 8'hFF;
            endcase
        end
    end

    assign crc_din = (r_q.st == ST_TX) ? lnk_tx_byte : lnk_rx_byte;

    // Next-state computation
    always_comb begin
        r_d         = r_q;
        r_d.ack_v   = 1'b0;
        r_d.ack_nak = 1'b0;

        if (r_q.st == ST_WAIT) begin
            if (cfg_rsp_valid) begin
                r_d.status          = '0;
                r_d.status[SB_MABT] = cfg_rsp_mabort;
                r_d.status[SB_TABT] = cfg_rsp_tabort;
                r_d.status[SB_OK]   = !(cfg_rsp_mabort || cfg_rsp_tabort);
                r_d.rdata           = cfg_rsp_data;
                r_d.rdy             = 1'b1;
                r_d.ack_v           = 1'b1;
                r_d.ack_nak         = cfg_rsp_mabort || cfg_rsp_tabort;
                r_d.st              = ST_SKIP;
            end else if (tmo) begin
                r_d.status         = '0;
                r_d.status[SB_TMO] = 1'b1;
                r_d.rdata          = '0;
                r_d.rdy            = 1'b1;
                r_d.ack_v          = 1'b1;
                r_d.ack_nak        = 1'b1;
                r_d.st             = ST_SKIP;
            end
        end else if (lnk_stop) begin
            r_d.st = ST_IDLE;
        end else if (lnk_start) begin
            r_d.st      = ST_ADDR;
            r_d.crc     = '0;
            r_d.got_cmd = 1'b0;
        end else if (lnk_rstart) begin
            r_d.st = ST_ADDR;
        end else if (r_q.st == ST_TX) begin
            if (lnk_tx_nak) begin
                r_d.st = ST_IDLE;
            end else if (lnk_tx_ack && (r_q.txi < tx_last)) begin
                r_d.crc = crc_nx;
                r_d.txi = r_q.txi + 3'd1;
            end
            if (lnk_rx_valid) begin
                r_d.ack_v   = 1'b1;
                r_d.ack_nak = 1'b1;
            end
        end else if (lnk_rx_valid) begin
            r_d.ack_v   = 1'b1;
            r_d.ack_nak = 1'b0;
            r_d.crc     = crc_nx;
            case (r_q.st)
                ST_ADDR: begin
                    if (lnk_rx_byte[7:1] != own_addr) begin
                        r_d.ack_nak = 1'b1;
                        r_d.st      = ST_SKIP;
                    end else if (!lnk_rx_byte[0]) begin
                        r_d.st = ST_CMD;
                    end else if (r_q.rdy && r_q.got_cmd) begin
                        r_d.st  = ST_TX;
                        r_d.txi = '0;
                    end else begin
                        r_d.ack_nak = 1'b1;
                        r_d.st      = ST_SKIP;
                    end
                end
                ST_CMD: begin
                    if ((lnk_rx_byte[3:2] != ICMD_RD_DWORD) || (lnk_rx_byte[1:0] == 2'b11)) begin
                        r_d.ack_nak = 1'b1;
                        r_d.st      = ST_SKIP;
                    end else begin
                        r_d.fin_end = lnk_rx_byte[CMD_END];
                        r_d.fin_pec = lnk_rx_byte[CMD_PEC];
                        r_d.got_cmd = 1'b1;
                        if (lnk_rx_byte[CMD_BEGIN]) r_d.ptr = '0;
                        case (lnk_rx_byte[1:0])
                            SZ_BLOCK: r_d.st = ST_CNT;
                            SZ_WORD:  begin r_d.st = ST_DATA; r_d.rem = 8'd2; end
                            default:  begin r_d.st = ST_DATA; r_d.rem = 8'd1; end
                        endcase
                    end
                end
                ST_CNT: begin
                    if (lnk_rx_byte == 8'd0) begin
                        r_d.ack_nak = 1'b1;
                        r_d.st      = ST_SKIP;
                    end else begin
                        r_d.rem = lnk_rx_byte;
                        r_d.st  = ST_DATA;
                    end
                end
                ST_DATA: begin
                    case (r_q.ptr)
                        3'd0:    r_d.bus        = lnk_rx_byte;
                        3'd1:    r_d.devfn      = lnk_rx_byte;
                        3'd2:    r_d.regn[7:0]  = lnk_rx_byte;
                        3'd3:    r_d.regn[15:8] = lnk_rx_byte;
                        default: ;
                    endcase
                    if (r_q.ptr < 3'(STAGE_BYTES)) r_d.ptr = r_q.ptr + 3'd1;
                    r_d.rem = r_q.rem - 8'd1;
                    if (r_q.rem == 8'd1) begin
                        if (r_q.fin_pec) begin
                            r_d.st = ST_PEC;
                        end else if (r_q.fin_end) begin
                            r_d.ack_v = 1'b0;
                            r_d.rdy   = 1'b0;
                            r_d.st    = ST_WAIT;
                        end else begin
                            r_d.st = ST_SKIP;
                        end
                    end
                end
                ST_PEC: begin
                    if (lnk_rx_byte != r_q.crc) begin
                        r_d.ack_nak = 1'b1;
                        r_d.st      = ST_SKIP;
                    end else if (r_q.fin_end) begin
                        r_d.ack_v = 1'b0;
                        r_d.rdy   = 1'b0;
                        r_d.st    = ST_WAIT;
                    end else begin
                        r_d.st = ST_SKIP;
                    end
                end
                default: begin
                    r_d.ack_nak = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lnk_ack_valid = r_q.ack_v;
    assign lnk_ack_nak   = r_q.ack_nak;
    assign lnk_hold      = (r_q.st == ST_WAIT);
    assign cfg_req       = (r_q.st == ST_WAIT);
    assign cfg_bus       = r_q.bus;
    assign cfg_devfn     = r_q.devfn;
    assign cfg_reg       = r_q.regn;

    AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_ack_valid |-> ($past(lnk_rx_valid) || $past(cfg_req))); // R14
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && $past(cfg_req)) |-> $stable({cfg_bus, cfg_devfn, cfg_reg})); // R4
    AST_GOOD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_rsp_valid && !cfg_rsp_mabort && !cfg_rsp_tabort)
            |=> (lnk_ack_valid && !lnk_ack_nak && !lnk_hold)); // R5
    AST_ABORT_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_rsp_valid && (cfg_rsp_mabort || cfg_rsp_tabort))
            |=> (lnk_ack_valid && lnk_ack_nak)); // R6
    AST_TMO_NAK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && tmo && !cfg_rsp_valid) |=> (lnk_ack_valid && lnk_ack_nak && !cfg_req)); // R7
endmodule

// File: tb/smb_cfgrd_bridge_tb.sv
module smb_cfgrd_bridge_tb;
    localparam int TMO = 40;
    localparam logic [3:0] STRAP  = 4'b1010;
    localparam logic [7:0] ADDR_W = {2'b11, STRAP[3], 1'b0, STRAP[2:0], 1'b0};
    localparam logic [7:0] ADDR_R = {2'b11, STRAP[3], 1'b0, STRAP[2:0], 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lnk_start = 0, lnk_rstart = 0, lnk_stop = 0, lnk_rx_valid = 0;
    logic [7:0] lnk_rx_byte = '0;
    logic lnk_ack_valid, lnk_ack_nak, lnk_hold;
    logic [7:0] lnk_tx_byte;
    logic lnk_tx_ack = 0, lnk_tx_nak = 0;
    logic cfg_req;
    logic [7:0] cfg_bus, cfg_devfn;
    logic [15:0] cfg_reg;
    logic cfg_rsp_valid = 0, cfg_rsp_mabort = 0, cfg_rsp_tabort = 0;
    logic [31:0] cfg_rsp_data = '0;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    smb_cfgrd_bridge #(.TMO_CYCLES(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .strap_addr(STRAP),
        .lnk_start(lnk_start), .lnk_rstart(lnk_rstart), .lnk_stop(lnk_stop),
        .lnk_rx_valid(lnk_rx_valid), .lnk_rx_byte(lnk_rx_byte),
        .lnk_ack_valid(lnk_ack_valid), .lnk_ack_nak(lnk_ack_nak), .lnk_hold(lnk_hold),
        .lnk_tx_byte(lnk_tx_byte), .lnk_tx_ack(lnk_tx_ack), .lnk_tx_nak(lnk_tx_nak),
        .cfg_req(cfg_req), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn), .cfg_reg(cfg_reg),
        .cfg_rsp_valid(cfg_rsp_valid), .cfg_rsp_data(cfg_rsp_data),
        .cfg_rsp_mabort(cfg_rsp_mabort), .cfg_rsp_tabort(cfg_rsp_tabort)
    );

    function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] x;
        x = c ^ b;
        for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic p_start();
        @(negedge clk) lnk_start = 1;
        @(negedge clk) lnk_start = 0;
    endtask
    task automatic p_rstart();
        @(negedge clk) lnk_rstart = 1;
        @(negedge clk) lnk_rstart = 0;
    endtask
    task automatic p_stop();
        @(negedge clk) lnk_stop = 1;
        @(negedge clk) lnk_stop = 0;
    endtask

    // Send one byte; sample the decision one cycle later
    task automatic xbyte(input logic [7:0] b, output logic a, output logic nk);
        @(negedge clk);
        lnk_rx_valid = 1;
        lnk_rx_byte  = b;
        @(negedge clk);
        lnk_rx_valid = 0;
        a  = lnk_ack_valid;
        nk = lnk_ack_nak;
    endtask

    // resp: 0 ok, 1 master abort, 2 target abort, 3 no response
    task automatic do_write(input logic [7:0] cmd, input int n, input logic [31:0] dat,
                            input bit bad_pec, input int resp, input logic [31:0] rdat,
                            input logic [31:0] exp_addr, input string tag);
        logic a, nk;
        logic [7:0] c, b;
        bit pec, launch;
        int k;
        pec    = cmd[4];
        launch = cmd[6] && !bad_pec;
        p_start();
        c = '0;
        xbyte(ADDR_W, a, nk); c = crc8(c, ADDR_W);
        chk(a && !nk, {tag, " R1 address ACK"}, {a, nk}, 2'b10);
        xbyte(cmd, a, nk); c = crc8(c, cmd);
        chk(a && !nk, {tag, " R2 command ACK"}, {a, nk}, 2'b10);
        if (cmd[1:0] == 2'b10) begin
            xbyte(8'(n), a, nk); c = crc8(c, 8'(n));
            chk(a && !nk, {tag, " R14 count ACK"}, {a, nk}, 2'b10);
        end
        for (int i = 0; i < n; i++) begin
            b = dat[31 - 8*i -: 8];
            xbyte(b, a, nk); c = crc8(c, b);
            if (i != n - 1 || pec || !launch)
                chk(a && !nk, {tag, " R14 data ACK"}, {a, nk}, 2'b10);
        end
        if (pec) begin
            b = bad_pec ? (c ^ 8'h5A) : c;
            xbyte(b, a, nk);
            if (bad_pec) begin
                chk(a && nk, {tag, " R10 bad PEC NAK"}, {a, nk}, 2'b11);
                repeat (3) @(negedge clk);
                chk(!cfg_req, {tag, " R10 no launch"}, cfg_req, 0);
            end else if (!launch) begin
                chk(a && !nk, {tag, " R10 PEC ACK"}, {a, nk}, 2'b10);
            end
        end
        if (launch) begin
            chk(!a && lnk_hold && cfg_req, {tag, " R4 held with request"},
                {a, lnk_hold, cfg_req}, 3'b011);
            chk({cfg_bus, cfg_devfn, cfg_reg} == exp_addr, {tag, " R3 staged address"},
                {cfg_bus, cfg_devfn, cfg_reg}, exp_addr);
            if (resp != 3) begin
                repeat (4) @(negedge clk);
                chk(lnk_hold && !lnk_ack_valid, {tag, " R4 hold kept"}, {lnk_hold, lnk_ack_valid}, 2'b10);
                cfg_rsp_valid  = 1;
                cfg_rsp_data   = rdat;
                cfg_rsp_mabort = (resp == 1);
                cfg_rsp_tabort = (resp == 2);
                @(negedge clk);
                cfg_rsp_valid = 0; cfg_rsp_mabort = 0; cfg_rsp_tabort = 0;
                if (resp == 0)
                    chk(lnk_ack_valid && !lnk_ack_nak && !lnk_hold, {tag, " R5 ACK on success"},
                        {lnk_ack_valid, lnk_ack_nak, lnk_hold}, 3'b100);
                else
                    chk(lnk_ack_valid && lnk_ack_nak, {tag, " R6 NAK on abort"},
                        {lnk_ack_valid, lnk_ack_nak}, 2'b11);
            end else begin
                k = 0;
                while (!lnk_ack_valid && k < TMO + 10) begin
                    @(negedge clk);
                    k++;
                end
                chk(k >= TMO && k <= TMO + 2, {tag, " R7 timeout window"}, k, TMO);
                chk(lnk_ack_valid && lnk_ack_nak, {tag, " R7 timeout NAK"},
                    {lnk_ack_valid, lnk_ack_nak}, 2'b11);
                @(negedge clk);
                chk(!cfg_req && !lnk_hold, {tag, " R7 request withdrawn"}, {cfg_req, lnk_hold}, 0);
            end
        end
        p_stop();
    endtask

    task automatic do_read(input bit pec, input bit exp_ok, input logic [7:0] exp_st,
                           input logic [31:0] exp_data, input string tag);
        logic a, nk;
        logic [7:0] c, cmd, e, got;
        int nb;
        cmd = pec ? 8'h12 : 8'h02;
        p_start();
        c = '0;
        xbyte(ADDR_W, a, nk); c = crc8(c, ADDR_W);
        xbyte(cmd, a, nk);    c = crc8(c, cmd);
        p_rstart();
        xbyte(ADDR_R, a, nk); c = crc8(c, ADDR_R);
        if (!exp_ok) begin
            chk(a && nk, {tag, " R13 read NAK without result"}, {a, nk}, 2'b11);
            p_stop();
            return;
        end
        chk(a && !nk, {tag, " R8 read address ACK"}, {a, nk}, 2'b10);
        nb = pec ? 7 : 6;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            lnk_tx_ack = 0;
            got = lnk_tx_byte;
            case (i)
                0: e = 8'd5;
                1: e = exp_st;
                2: e = exp_data[31:24];
                3: e = exp_data[23:16];
                4: e = exp_data[15:8];
                5: e = exp_data[7:0];
                default: e = c;
            endcase
            if (i == 6)      chk(got == e, {tag, " R11 read PEC"}, got, e);
            else if (i == 1) chk(got == e, {tag, " R9 status byte"}, got, e);
            else             chk(got == e, {tag, " R8 read byte"}, got, e);
            if (i < 6) c = crc8(c, e);
            if (i == nb - 1) lnk_tx_nak = 1;
            else             lnk_tx_ack = 1;
        end
        @(negedge clk);
        lnk_tx_ack = 0; lnk_tx_nak = 0;
        @(negedge clk);
        chk(lnk_tx_byte == 8'hFF, {tag, " R12 idle after master NAK"}, lnk_tx_byte, 8'hFF);
        p_stop();
    endtask

    task automatic t_reset();
        chk(!lnk_ack_valid && !lnk_hold && !cfg_req, "R4 reset outputs quiet",
            {lnk_ack_valid, lnk_hold, cfg_req}, 0);
        chk(lnk_tx_byte == 8'hFF, "R12 reset tx idle", lnk_tx_byte, 8'hFF);
    endtask

    task automatic t_wrong_addr();
        logic a, nk;
        p_start();
        xbyte(8'hC4, a, nk);
        chk(a && nk, "R1 foreign address NAK", {a, nk}, 2'b11);
        xbyte(8'hD2, a, nk);
        chk(a && nk, "R1 later byte NAK", {a, nk}, 2'b11);
        p_stop();
        p_start();
        xbyte(ADDR_R, a, nk);
        chk(a && nk, "R13 read without command NAK", {a, nk}, 2'b11);
        p_stop();
    endtask

    task automatic t_bad_icmd();
        logic a, nk;
        p_start();
        xbyte(ADDR_W, a, nk);
        xbyte(8'hC6, a, nk);
        chk(a && nk, "R2 internal command not read DWORD NAK", {a, nk}, 2'b11);
        p_stop();
        p_start();
        xbyte(ADDR_W, a, nk);
        xbyte(8'hC3, a, nk);
        chk(a && nk, "R2 size 11 NAK", {a, nk}, 2'b11);
        p_stop();
        chk(!cfg_req, "R2 no launch", cfg_req, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        do_read(1, 0, 8'h00, 32'h0, "not-ready");
        t_wrong_addr();
        t_bad_icmd();
        // Block write with PEC, success, then read back with PEC
        do_write(8'hD2, 4, 32'h12347856, 0, 0, 32'hDEADBEEF, {8'h12, 8'h34, 16'h5678}, "blk-pec");
        do_read(1, 1, 8'h01, 32'hDEADBEEF, "blk-pec");
        // Mixed byte / word / byte without PEC, master abort
        do_write(8'h80, 1, 32'h21000000, 0, 0, 32'h0, 32'h0, "mix-a");
        do_write(8'h01, 2, 32'h43650000, 0, 0, 32'h0, 32'h0, "mix-b");
        do_write(8'h40, 1, 32'h87000000, 0, 1, 32'h11223344, {8'h21, 8'h43, 16'h8765}, "mix-c");
        do_read(0, 1, 8'h20, 32'h11223344, "mix");
        // Block without PEC, target abort, five data bytes (fifth ignored)
        do_write(8'hC2, 5, 32'hA1B2C3D4, 0, 2, 32'hCAFEF00D, {8'hA1, 8'hB2, 16'hD4C3}, "blk-tabt");
        do_read(1, 1, 8'h10, 32'hCAFEF00D, "blk-tabt");
        // Corrupted PEC: no launch, previous result still held
        do_write(8'hD2, 4, 32'h01020304, 1, 0, 32'h0, 32'h0, "bad-pec");
        do_read(1, 1, 8'h10, 32'hCAFEF00D, "R10 bad-pec");
        // Timeout
        do_write(8'hC2, 4, 32'h05060708, 0, 3, 32'h0, {8'h05, 8'h06, 16'h0807}, "tmo");
        do_read(0, 1, 8'h80, 32'h0, "tmo");
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule